// File: doc/BRIEF.md
# Indirect Memory Access Register Port

This block lets a host with a narrow, byte-wide register bus reach wide internal memories that are not mapped into its address space. The host writes a handful of directly addressed staging registers: the low address byte and, for writes, the low and high data bytes. A final write to a combined code/high-address register then issues one access to the memory side. The memories themselves sit outside the block. The block drives them through a single-cycle request and waits for an acknowledge.

The two top bits of the command byte pick the target memory (connection memory or data memory) and the direction. The remaining six bits supply the upper address bits. A busy flag in the status register stays set from the launch until the memory side acknowledges. For reads, software polls this flag and then fetches the result from two read-data registers. A command written while an access is still in flight is dropped, and a sticky error flag records the collision.

Top module: `iap_port`

## Requirements
- R1: After reset, the memory request is low. Status reads 0, and the staging and read-data registers all read 0.
- R2: Register selects are 0 low address, 1 write-data low, 2 write-data high, 3 command, 4 status, 5 read-data low, 6 read-data high. Registers 0, 1 and 2 read back the last byte written to them. Registers 3 and 7 read as 0.
- R3: A write to register 3 while idle raises `mem_req` in the following cycle for exactly one cycle. Busy is set in that same cycle.
- R4: Command byte bit 7 selects the target (0 connection memory, 1 data memory) and bit 6 selects the direction (1 write, 0 read). During the access, `mem_addr` equals {command bits 5:0, low address byte} and `mem_wdata` equals {write-data high, write-data low}.
- R5: Busy stays set until `mem_ack` is sampled high, and it reads 0 in the cycle after that edge.
- R6: When a read completes, register 5 holds `mem_rdata[7:0]` and register 6 holds `mem_rdata[15:8]`. A write completion leaves both registers unchanged.
- R7: A write to register 3 while busy issues no request, does not alter the access in flight, and sets the error flag. The error flag stays set until reset.
- R8: The status byte carries busy in bit 0 and the error flag in bit 1, and all other bits are 0.
- R9: The memory-side target, direction, address and write data stay fixed from launch to acknowledge, even if the host rewrites registers 0, 1 or 2 meanwhile.
- R10: An acknowledge that arrives while idle changes neither the read-data registers nor the status.
- R11: Writes to any register other than 3 never raise `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected register |
| mem_req | output | 1 | One-cycle access request to the memory side |
| mem_target | output | 1 | 0 connection memory, 1 data memory |
| mem_write | output | 1 | 1 write access, 0 read access |
| mem_addr | output | 14 | Access address |
| mem_wdata | output | 16 | Access write data |
| mem_ack | input | 1 | Memory side completion |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
A stuck or early-clearing busy flag appears in the status byte within one cycle of the acknowledge edge. A wrongly latched access appears on `mem_addr`/`mem_wdata` in the request cycle itself. A corrupted read capture shows up in registers 5 and 6 one cycle after the acknowledge. The bench sweeps every target/direction pair against several addresses, data values and acknowledge latencies, including an acknowledge in the request cycle. It then provokes collisions and stray acknowledges, so that each wrong state is seen at the ports within a cycle or two.

// File: rtl/iap_pkg.sv
package iap_pkg;

    localparam int BYTE_W     = 8;
    localparam int CODE_W     = 2;
    localparam int HI_ADDR_W  = BYTE_W - CODE_W;
    localparam int MEM_ADDR_W = BYTE_W + HI_ADDR_W;
    localparam int MEM_DATA_W = 2 * BYTE_W;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        REG_ADDR_LO  = 3'd0,
        REG_WDATA_LO = 3'd1,
        REG_WDATA_HI = 3'd2,
        REG_CMD      = 3'd3,
        REG_STATUS   = 3'd4,
        REG_RDATA_LO = 3'd5,
        REG_RDATA_HI = 3'd6
    } reg_sel_e;

    typedef enum logic {
        TGT_CONN = 1'b0,
        TGT_DATA = 1'b1
    } target_e;

    typedef struct packed {
        target_e                 tgt;
        logic                    wr;
        logic [MEM_ADDR_W-1:0]   addr;
        logic [MEM_DATA_W-1:0]   wdata;
    } access_t;

    function automatic access_t decode_cmd(
        input logic [BYTE_W-1:0]     cmd,
        input logic [BYTE_W-1:0]     addr_lo,
        input logic [MEM_DATA_W-1:0] wdata
    );
        access_t a;
        a.tgt   = target_e'(cmd[BYTE_W-1]);
        a.wr    = cmd[BYTE_W-2];
        a.addr  = {cmd[HI_ADDR_W-1:0], addr_lo};
        a.wdata = wdata;
        return a;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic busy, input logic err);
        return {{(BYTE_W-2){1'b0}}, err, busy};
    endfunction

endpackage

// File: rtl/iap_regfile.sv
module iap_regfile
    import iap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_we,
    input  logic [SEL_W-1:0]       host_addr,
    input  logic [BYTE_W-1:0]      host_wdata,
    output logic [BYTE_W-1:0]      addr_lo,
    output logic [MEM_DATA_W-1:0]  wdata
);

    logic [BYTE_W-1:0] wd_lo_q, wd_hi_q, alo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alo_q   <= '0;
            wd_lo_q <= '0;
            wd_hi_q <= '0;
        end else if (host_we) begin
            case (host_addr)
                REG_ADDR_LO:  alo_q   <= host_wdata;
                REG_WDATA_LO: wd_lo_q <= host_wdata;
                REG_WDATA_HI: wd_hi_q <= host_wdata;
                default: ;
            endcase
        end
    end

    assign addr_lo = alo_q;
    assign wdata   = {wd_hi_q, wd_lo_q};

endmodule

// File: rtl/iap_engine.sv
module iap_engine
    import iap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch,
    input  access_t                next_acc,
    input  logic                   mem_ack,
    input  logic [MEM_DATA_W-1:0]  mem_rdata,
    output access_t                cur_acc,
    output logic                   req,
    output logic                   busy,
    output logic                   err,
    output logic [MEM_DATA_W-1:0]  rdata
);

    access_t                acc_q;
    logic                   busy_q, req_q, err_q;
    logic [MEM_DATA_W-1:0]  rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            busy_q  <= 1'b0;
            req_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (busy_q) begin
                if (mem_ack) begin
                    busy_q <= 1'b0;
                    if (!acc_q.wr) rdata_q <= mem_rdata;
                end
                if (launch) err_q <= 1'b1;
            end else if (launch) begin
                busy_q <= 1'b1;
                req_q  <= 1'b1;
                acc_q  <= next_acc;
            end
        end
    end

    assign cur_acc = acc_q;
    assign req     = req_q;
    assign busy    = busy_q;
    assign err     = err_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/iap_readmux.sv
module iap_readmux
    import iap_pkg::*;
(
    input  logic [SEL_W-1:0]       sel,
    input  logic [BYTE_W-1:0]      addr_lo,
    input  logic [MEM_DATA_W-1:0]  wdata,
    input  logic [MEM_DATA_W-1:0]  rdata,
    input  logic                   busy,
    input  logic                   err,
    output logic [BYTE_W-1:0]      dout
);

    always_comb begin
        case (sel)
            REG_ADDR_LO:  dout = addr_lo;
            REG_WDATA_LO: dout = wdata[BYTE_W-1:0];
            REG_WDATA_HI: dout = wdata[MEM_DATA_W-1:BYTE_W];
            REG_STATUS:   dout = status_byte(busy, err);
            REG_RDATA_LO: dout = rdata[BYTE_W-1:0];
            REG_RDATA_HI: dout = rdata[MEM_DATA_W-1:BYTE_W];
            default:      dout = '0;
        endcase
    end

endmodule

// File: rtl/iap_port.sv
module iap_port
    import iap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_we,
    input  logic [SEL_W-1:0]       host_addr,
    input  logic [BYTE_W-1:0]      host_wdata,
    output logic [BYTE_W-1:0]      host_rdata,
    output logic                   mem_req,
    output logic                   mem_target,
    output logic                   mem_write,
    output logic [MEM_ADDR_W-1:0]  mem_addr,
    output logic [MEM_DATA_W-1:0]  mem_wdata,
    input  logic                   mem_ack,
    input  logic [MEM_DATA_W-1:0]  mem_rdata
);

    logic [BYTE_W-1:0]     addr_lo;
    logic [MEM_DATA_W-1:0] stage_wdata;
    logic [MEM_DATA_W-1:0] rdata;
    logic                  busy, err, launch;
    access_t               next_acc, cur_acc;

    assign launch   = host_we && (host_addr == REG_CMD);
    assign next_acc = decode_cmd(host_wdata, addr_lo, stage_wdata);

    iap_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .addr_lo    (addr_lo),
        .wdata      (stage_wdata)
    );

    iap_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .next_acc  (next_acc),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .cur_acc   (cur_acc),
        .req       (mem_req),
        .busy      (busy),
        .err       (err),
        .rdata     (rdata)
    );

    iap_readmux u_rmux (
        .sel     (host_addr),
        .addr_lo (addr_lo),
        .wdata   (stage_wdata),
        .rdata   (rdata),
        .busy    (busy),
        .err     (err),
        .dout    (host_rdata)
    );

    assign mem_target = cur_acc.tgt;
    assign mem_write  = cur_acc.wr;
    assign mem_addr   = cur_acc.addr;
    assign mem_wdata  = cur_acc.wdata;

endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk
    import iap_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   host_we,
    input logic [SEL_W-1:0]       host_addr,
    input logic                   mem_req,
    input logic                   mem_ack,
    input logic                   busy,
    input logic                   err,
    input logic                   mem_target,
    input logic                   mem_write,
    input logic [MEM_ADDR_W-1:0]  mem_addr,
    input logic [MEM_DATA_W-1:0]  mem_wdata
);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R3
    AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (rst) mem_req |-> busy); // R3
    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == REG_CMD && !busy) |=> (mem_req && busy)); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && !mem_ack) |=> busy); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) (busy && mem_ack) |=> !busy); // R5
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we && host_addr == REG_CMD) |=> (!mem_req && err)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R7
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_req) |-> ($stable(mem_addr) && $stable(mem_wdata)
                                && $stable(mem_target) && $stable(mem_write))); // R9
    AST_OTHER_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(host_we && host_addr == REG_CMD)) |=> !mem_req); // R11

endmodule

bind iap_port iap_port_chk u_chk (.*);

// File: tb/iap_port_bench.sv
module iap_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        mem_req, mem_target, mem_write;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'd0;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_rd = 16'd0;

    always #10 clk = ~clk;

    iap_port u_iap_port (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_target(mem_target), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [15:0] pattern(input logic [13:0] a, input int k);
        return 16'(a * 16'd37 + 16'h5A3 + k * 16'h1111);
    endfunction

    task automatic access(input bit tgt, input bit wr, input logic [13:0] a,
                          input logic [15:0] wd, input int lat, input int k);
        logic [7:0] b;
        logic [15:0] rd;
        if (wr) begin
            host_wr(3'd1, wd[7:0]);
            check("R11 no req after wdata lo", {31'd0, mem_req}, 32'd0);
            host_wr(3'd2, wd[15:8]);
        end
        host_wr(3'd0, a[7:0]);
        check("R11 no req after addr lo", {31'd0, mem_req}, 32'd0);
        host_wr(3'd3, {tgt, wr, a[13:8]});
        check("R3 req pulse", {31'd0, mem_req}, 32'd1);
        check("R4 target", {31'd0, mem_target}, {31'd0, tgt});
        check("R4 direction", {31'd0, mem_write}, {31'd0, wr});
        check("R4 address", {18'd0, mem_addr}, {18'd0, a});
        if (wr) check("R4 wdata", {16'd0, mem_wdata}, {16'd0, wd});
        host_rd(3'd4, b);
        check("R8 busy in status", {24'd0, b}, 32'd1);
        rd = pattern(a, k);
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            check("R3 req single cycle", {31'd0, mem_req}, 32'd0);
            host_rd(3'd4, b);
            check("R5 busy held", {24'd0, b}, 32'd1);
        end
        mem_ack = 1'b1; mem_rdata = rd;
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 16'hDEAD;
        host_rd(3'd4, b);
        check("R5 busy cleared", {24'd0, b}, 32'd0);
        if (!wr) exp_rd = rd;
        host_rd(3'd5, b);
        check("R6 rdata lo", {24'd0, b}, {24'd0, exp_rd[7:0]});
        host_rd(3'd6, b);
        check("R6 rdata hi", {24'd0, b}, {24'd0, exp_rd[15:8]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] b;
        logic [13:0] addrs [3];
        addrs[0] = 14'h0000; addrs[1] = 14'h3FFF; addrs[2] = 14'h2A5C;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check("R1 req low", {31'd0, mem_req}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            host_rd(3'(r), b);
            check("R1 register zero", {24'd0, b}, 32'd0);
        end

        // R2 staging readback
        host_wr(3'd0, 8'hA5); host_wr(3'd1, 8'h3C); host_wr(3'd2, 8'hF0);
        host_wr(3'd7, 8'hFF);
        check("R11 no req after unmapped", {31'd0, mem_req}, 32'd0);
        host_rd(3'd0, b); check("R2 addr lo", {24'd0, b}, 32'hA5);
        host_rd(3'd1, b); check("R2 wdata lo", {24'd0, b}, 32'h3C);
        host_rd(3'd2, b); check("R2 wdata hi", {24'd0, b}, 32'hF0);
        host_rd(3'd3, b); check("R2 cmd reads zero", {24'd0, b}, 32'h00);
        host_rd(3'd7, b); check("R2 unmapped zero", {24'd0, b}, 32'h00);

        // R3-R6 sweep
        for (int t = 0; t < 2; t++)
            for (int w = 0; w < 2; w++)
                for (int ai = 0; ai < 3; ai++)
                    for (int lat = 0; lat < 4; lat++)
                        access(t[0], w[0], addrs[ai],
                               16'(ai * 16'h1357 + lat * 16'h0F0F + t + 2 * w),
                               lat, t * 24 + w * 12 + ai * 4 + lat);

        // R10 stray ack while idle
        mem_ack = 1'b1; mem_rdata = 16'h1234;
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0;
        host_rd(3'd5, b); check("R10 rdata lo unchanged", {24'd0, b}, {24'd0, exp_rd[7:0]});
        host_rd(3'd6, b); check("R10 rdata hi unchanged", {24'd0, b}, {24'd0, exp_rd[15:8]});
        host_rd(3'd4, b); check("R10 status unchanged", {24'd0, b}, 32'd0);

        // R7 and R9 collision while busy
        host_wr(3'd1, 8'h11); host_wr(3'd2, 8'h22); host_wr(3'd0, 8'h33);
        host_wr(3'd3, 8'hC5);
        check("R3 launch", {31'd0, mem_req}, 32'd1);
        host_wr(3'd3, 8'h0A);
        check("R7 no second req", {31'd0, mem_req}, 32'd0);
        check("R7 address kept", {18'd0, mem_addr}, 32'h0533);
        check("R7 target kept", {31'd0, mem_target}, 32'd1);
        host_rd(3'd4, b); check("R7 error and busy", {24'd0, b}, 32'h3);
        host_wr(3'd0, 8'h99); host_wr(3'd1, 8'h77);
        check("R9 address held", {18'd0, mem_addr}, 32'h0533);
        check("R9 wdata held", {16'd0, mem_wdata}, 32'h2211);
        check("R9 direction held", {31'd0, mem_write}, 32'd1);
        host_rd(3'd0, b); check("R2 addr lo rewritten while busy", {24'd0, b}, 32'h99);
        mem_ack = 1'b1; mem_rdata = 16'hBEEF;
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0;
        host_rd(3'd4, b); check("R7 error sticky after ack", {24'd0, b}, 32'h2);
        host_rd(3'd5, b); check("R6 write leaves rdata", {24'd0, b}, {24'd0, exp_rd[7:0]});
        repeat (3) begin @(posedge clk); @(negedge clk); end
        host_rd(3'd4, b); check("R7 error still set", {24'd0, b}, 32'h2);

        summary();
    end

endmodule